// File: doc/BRIEF.md
# Truncating Multiply / Accumulate / Subtract Unit

This block is the integer multiply unit of a small processor datapath. A request names two factors, a third operand and one of three operations: plain product, product plus the third operand, or the third operand minus the product. Every result is cut to the low 32 bits. Because only the low half of the product is kept, the same logic serves signed and unsigned operands. The unit therefore has no signedness input.

The unit also takes a four-bit condition-code vector and returns a new one. For a plain product, the caller can ask the unit to rewrite the negative and zero bits from the result. The carry and overflow bits always come back exactly as they went in. The two accumulating forms never touch any flag.

The handshake is a start strobe and a one-cycle done pulse. By default the product comes from a shift-and-add engine that takes one multiplier bit per clock. A parameter swaps in a single-cycle product instead.

Top module: `mulacc_unit`

## Requirements
- R1: With op_sel = 2'b00, res is the low 32 bits of opnd_a × opnd_b.
- R2: With op_sel = 2'b01, res is the low 32 bits of (opnd_a × opnd_b) + opnd_c. A carry out of bit 31 is discarded with no indication.
- R3: With op_sel = 2'b10, res is the low 32 bits of opnd_c − (opnd_a × opnd_b). The product is the subtrahend, and a borrow wraps silently.
- R4: op_sel = 2'b11 behaves exactly like 2'b00, including the flag rewrite.
- R5: res is the same bit pattern whether the operands are read as two's-complement or as unsigned values.
- R6: The condition-code layout is bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V. When upd_flags is high with a plain-product op, cc_out bit 3 equals res bit 31, and cc_out bit 2 is 1 exactly when res is zero.
- R7: cc_out bits 1 and 0 always equal cc_in bits 1 and 0 as sampled at the accepted start, whatever op or upd_flags is.
- R8: In these cases cc_out equals the cc_in sampled at start on all four bits: op_sel 01 or 10 (even with upd_flags high), and any op with upd_flags low.
- R9: done is high for exactly one cycle. With ITERATIVE = 1 it rises WIDTH clock edges after the edge that accepts start. res and cc_out keep their values until the next done.
- R10: A start raised while an operation is in flight is ignored. It produces no extra done and does not alter the running result.
- R11: While and right after reset, res = 0, cc_out = 0 and done = 0, and the unit is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken only when idle |
| op_sel | input | 2 | 00 product, 01 add third operand, 10 subtract from third operand, 11 as 00 |
| upd_flags | input | 1 | Ask for N/Z rewrite (plain product only) |
| opnd_a | input | 32 | First factor |
| opnd_b | input | 32 | Second factor |
| opnd_c | input | 32 | Addend or minuend |
| cc_in | input | 4 | Incoming flags {N,Z,C,V} |
| res | output | 32 | Truncated result |
| cc_out | output | 4 | Outgoing flags {N,Z,C,V} |
| done | output | 1 | One-cycle pulse, result valid |

## Verification
The embedded properties take three things for granted. First, op_sel, upd_flags, opnd_c and cc_in carry known values in the cycle that start is accepted, because that is the only cycle they are captured. Second, reset is held across at least one rising edge. Third, no X reaches start. The bench drives every input on the falling edge and holds start for one cycle only. It keeps all fields defined on every request, including the stray start raised mid-operation. Expected results are computed from the arithmetic definition with wider intermediates and then truncated.

// File: rtl/mulacc_pkg.sv
`timescale 1ns/1ps
package mulacc_pkg;
  localparam logic [1:0] OP_MUL = 2'b00;
  localparam logic [1:0] OP_ADD = 2'b01;
  localparam logic [1:0] OP_SUB = 2'b10;
  localparam logic [1:0] OP_RSV = 2'b11;

  localparam int unsigned CC_N = 3;
  localparam int unsigned CC_Z = 2;
  localparam int unsigned CC_C = 1;
  localparam int unsigned CC_V = 0;
  localparam int unsigned CC_W = 4;
endpackage

// File: rtl/mulacc_core.sv
`timescale 1ns/1ps
module mulacc_core #(
  parameter int unsigned WIDTH     = 32,
  parameter bit          ITERATIVE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic             busy,
  output logic             fin,
  output logic [WIDTH-1:0] prod
);
  localparam int unsigned CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  generate
    if (ITERATIVE) begin : g_iter
      logic             busy_q, busy_d;
      logic [CW-1:0]    cnt_q, cnt_d;
      logic [WIDTH-1:0] acc_q, acc_d;
      logic [WIDTH-1:0] mcand_q, mcand_d;
      logic [WIDTH-1:0] mplier_q, mplier_d;
      logic             last;
      logic             en;
      logic [WIDTH-1:0] partial;

      always_comb begin
        last     = busy_q && (cnt_q == CW'(WIDTH - 1));
        partial  = acc_q + (mplier_q[0] ? mcand_q : '0);
        en       = load || busy_q;
        busy_d   = busy_q;
        cnt_d    = cnt_q;
        acc_d    = acc_q;
        mcand_d  = mcand_q;
        mplier_d = mplier_q;
        if (load) begin
          busy_d   = 1'b1;
          cnt_d    = '0;
          acc_d    = '0;
          mcand_d  = a;
          mplier_d = b;
        end else if (busy_q) begin
          acc_d    = partial;
          mcand_d  = mcand_q << 1;
          mplier_d = mplier_q >> 1;
          cnt_d    = cnt_q + CW'(1);
          if (last) busy_d = 1'b0;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          busy_q   <= 1'b0;
          cnt_q    <= '0;
          acc_q    <= '0;
          mcand_q  <= '0;
          mplier_q <= '0;
        end else if (en) begin
          busy_q   <= busy_d;
          cnt_q    <= cnt_d;
          acc_q    <= acc_d;
          mcand_q  <= mcand_d;
          mplier_q <= mplier_d;
        end
      end

      assign busy = busy_q;
      assign fin  = last;
      assign prod = partial;

      assert_stays_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !last |=> busy_q);
      assert_fin_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> !last);
      assert_load_begins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy_q && (cnt_q == '0));
    end else begin : g_comb
      assign busy = 1'b0;
      assign fin  = load;
      assign prod = a * b;
    end
  endgenerate
endmodule

// File: rtl/mulacc_post.sv
`timescale 1ns/1ps
module mulacc_post
  import mulacc_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [1:0]       op,
  input  logic             upd,
  input  logic [WIDTH-1:0] prod,
  input  logic [WIDTH-1:0] c,
  input  logic [CC_W-1:0]  cc,
  output logic [WIDTH-1:0] value,
  output logic [CC_W-1:0]  cc_new
);
  logic is_plain;

  always_comb begin
    case (op)
      OP_ADD:  value = prod + c;
      OP_SUB:  value = c - prod;
      default: value = prod;
    endcase
    is_plain = (op == OP_MUL) || (op == OP_RSV);
    cc_new   = cc;
    if (upd && is_plain) begin
      cc_new[CC_N] = value[WIDTH-1];
      cc_new[CC_Z] = (value == '0);
    end
  end
endmodule

// File: rtl/mulacc_unit.sv
`timescale 1ns/1ps
module mulacc_unit
  import mulacc_pkg::*;
#(
  parameter int unsigned WIDTH     = 32,
  parameter bit          ITERATIVE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       op_sel,
  input  logic             upd_flags,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [WIDTH-1:0] opnd_c,
  input  logic [CC_W-1:0]  cc_in,
  output logic [WIDTH-1:0] res,
  output logic [CC_W-1:0]  cc_out,
  output logic             done
);
  logic             busy, fin, load;
  logic [WIDTH-1:0] prod;
  logic [1:0]       op_q, op_v;
  logic             upd_q, upd_v;
  logic [WIDTH-1:0] c_q, c_v;
  logic [CC_W-1:0]  ccs_q, cc_v;
  logic [WIDTH-1:0] value;
  logic [CC_W-1:0]  cc_new;
  logic [WIDTH-1:0] res_q;
  logic [CC_W-1:0]  cco_q;
  logic             done_q;

  assign load = start && !busy;

  mulacc_core #(.WIDTH(WIDTH), .ITERATIVE(ITERATIVE)) i_core (
    .clk(clk), .rst_n(rst_n), .load(load), .a(opnd_a), .b(opnd_b),
    .busy(busy), .fin(fin), .prod(prod)
  );

  // capture of the non-product fields at acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= OP_MUL;
      upd_q <= 1'b0;
      c_q   <= '0;
      ccs_q <= '0;
    end else if (load) begin
      op_q  <= op_sel;
      upd_q <= upd_flags;
      c_q   <= opnd_c;
      ccs_q <= cc_in;
    end
  end

  always_comb begin
    op_v  = load ? op_sel    : op_q;
    upd_v = load ? upd_flags : upd_q;
    c_v   = load ? opnd_c    : c_q;
    cc_v  = load ? cc_in     : ccs_q;
  end

  mulacc_post #(.WIDTH(WIDTH)) i_post (
    .op(op_v), .upd(upd_v), .prod(prod), .c(c_v), .cc(cc_v),
    .value(value), .cc_new(cc_new)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      cco_q <= '0;
    end else if (fin) begin
      res_q <= value;
      cco_q <= cc_new;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= fin;
  end

  assign res    = res_q;
  assign cc_out = cco_q;
  assign done   = done_q;

  assert_cv_passed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> cco_q[CC_C:CC_V] == $past(cc_v[CC_C:CC_V]));
  assert_flags_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && $past(!upd_v || op_v == OP_ADD || op_v == OP_SUB) |-> cco_q == $past(cc_v));
  assert_nz_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && $past(upd_v && (op_v == OP_MUL || op_v == OP_RSV))
      |-> (cco_q[CC_Z] == (res_q == '0)) && (cco_q[CC_N] == res_q[WIDTH-1]));
  assert_hold_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fin) |-> $stable(res_q) && $stable(cco_q));
  assert_idle_after_reset_R11: assert property (@(posedge clk)
    !rst_n |=> !done_q && (res_q == '0) && (cco_q == '0));
endmodule

// File: tb/test_mulacc_unit.sv
`timescale 1ns/1ps
module test_mulacc_unit;
  localparam int W   = 32;
  localparam bit ITR = 1'b1;
  localparam int LAT = ITR ? W : 0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op_sel = 2'b00;
  logic        upd_flags = 1'b0;
  logic [31:0] opnd_a = '0, opnd_b = '0, opnd_c = '0;
  logic [3:0]  cc_in = '0;
  logic [31:0] res;
  logic [3:0]  cc_out;
  logic        done;

  typedef struct {
    logic [31:0] r;
    logic [3:0]  f;
    int          cyc;
    string       tag;
  } exp_t;
  exp_t sb[$];

  int checks = 0, errors = 0, cyc = 0, n_done = 0;
  bit finished = 1'b0;
  logic [31:0] last_r;
  logic [3:0]  last_f;

  mulacc_unit #(.WIDTH(W), .ITERATIVE(ITR)) i_mulacc_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .upd_flags(upd_flags),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c), .cc_in(cc_in),
    .res(res), .cc_out(cc_out), .done(done)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] m_res(logic [1:0] op, logic [31:0] a, logic [31:0] b, logic [31:0] c);
    logic [63:0] p;
    p = {32'd0, a} * {32'd0, b};
    case (op)
      2'b01:   m_res = 32'(p + {32'd0, c});
      2'b10:   m_res = 32'({32'd0, c} - p);
      default: m_res = p[31:0];
    endcase
  endfunction

  function automatic logic [3:0] m_cc(logic [1:0] op, logic upd, logic [31:0] r, logic [3:0] cc);
    if (upd && (op == 2'b00 || op == 2'b11)) m_cc = {r[31], r == 32'd0, cc[1:0]};
    else m_cc = cc;
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // monitor: pop and compare on each done
  always @(negedge clk) begin
    if (rst_n && done) begin
      n_done++;
      if (sb.size() == 0) begin
        check(1'b0, "R10 unexpected done", 64'(res), 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(res == e.r, {e.tag, " result"}, 64'(res), 64'(e.r));
        check(cc_out == e.f, {e.tag, " flags"}, 64'(cc_out), 64'(e.f));
        check(cyc == e.cyc, "R9 latency", 64'(cyc), 64'(e.cyc));
        last_r = e.r;
        last_f = e.f;
      end
    end
  end

  task automatic drive(logic [1:0] op, logic upd, logic [31:0] a, logic [31:0] b,
                       logic [31:0] c, logic [3:0] cc);
    op_sel = op; upd_flags = upd; opnd_a = a; opnd_b = b; opnd_c = c; cc_in = cc;
    start = 1'b1;
  endtask

  task automatic run(logic [1:0] op, logic upd, logic [31:0] a, logic [31:0] b,
                     logic [31:0] c, logic [3:0] cc, string tag);
    exp_t e;
    int prev;
    @(negedge clk);
    drive(op, upd, a, b, c, cc);
    e.r = m_res(op, a, b, c);
    e.f = m_cc(op, upd, e.r, cc);
    e.cyc = cyc + 1 + LAT;
    e.tag = tag;
    sb.push_back(e);
    prev = n_done;
    @(negedge clk);
    start = 1'b0;
    while (n_done == prev) @(negedge clk);
    if (ITR) begin
      @(negedge clk);
      check(done == 1'b0, "R9 one-cycle pulse", 64'(done), 64'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(res == 32'd0, "R11 reset res", 64'(res), 64'd0);
    check(cc_out == 4'd0, "R11 reset cc", 64'(cc_out), 64'd0);
    check(done == 1'b0, "R11 reset done", 64'(done), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(done == 1'b0 && res == 32'd0, "R11 idle after release", 64'(res), 64'd0);

    run(2'b00, 1'b0, 32'd7, 32'd6, 32'd99, 4'b0000, "R1 small product");
    run(2'b00, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0, 4'b1010, "R1 all-ones squared");
    run(2'b00, 1'b1, 32'h8000_0000, 32'd2, 32'd0, 4'b0000, "R6 wrap to zero sets Z");
    run(2'b00, 1'b1, 32'hFFFF_FFFF, 32'd2, 32'd0, 4'b0100, "R6 negative sets N");
    run(2'b00, 1'b1, 32'h8000_0000, 32'h8000_0000, 32'd0, 4'b1111, "R6 R7 zero with C V kept");
    run(2'b01, 1'b0, 32'd1000, 32'd3000, 32'd17, 4'b0000, "R2 accumulate");
    run(2'b01, 1'b1, 32'hFFFF_FFFF, 32'd1, 32'd1, 4'b1001, "R2 R8 accumulate wraps to zero");
    run(2'b10, 1'b0, 32'd2, 32'd5, 32'd3, 4'b0000, "R3 subtract borrow");
    run(2'b10, 1'b1, 32'd4, 32'd5, 32'd20, 4'b0110, "R3 R8 subtract to zero");
    run(2'b11, 1'b1, 32'd0, 32'h1234_5678, 32'd5, 4'b1011, "R4 reserved op as product");
    run(2'b00, 1'b0, 32'h8000_0000, 32'hFFFF_FFFF, 32'd0, 4'b0101, "R8 no update keeps flags");
    run(2'b00, 1'b1, 32'hFFFF_FFFD, 32'd5, 32'd0, 4'b0011, "R7 C V pass");

    // R5: signed reading gives the same pattern as unsigned
    begin
      logic signed [31:0] sa, sb_;
      logic [31:0] sprod;
      sa = -32'sd3; sb_ = 32'sd5;
      sprod = 32'(sa * sb_);
      check(sprod == m_res(2'b00, sa, sb_, 32'd0), "R5 model agreement", 64'(sprod), 64'(m_res(2'b00, sa, sb_, 32'd0)));
      run(2'b00, 1'b0, sa, sb_, 32'd0, 4'b0000, "R5 negative operand");
      check(res == sprod, "R5 signed product", 64'(res), 64'(sprod));
      sa = -32'sd7; sb_ = -32'sd9;
      sprod = 32'(32'sd100 - sa * sb_);
      run(2'b10, 1'b0, sa, sb_, 32'd100, 4'b0000, "R5 signed subtract");
      check(res == sprod, "R5 signed subtract value", 64'(res), 64'(sprod));
    end

    // R9: outputs hold while idle
    repeat (5) @(negedge clk);
    check(res == last_r, "R9 result held", 64'(res), 64'(last_r));
    check(cc_out == last_f, "R9 flags held", 64'(cc_out), 64'(last_f));

    // R10: stray start in flight
    if (ITR) begin
      exp_t e;
      int prev;
      @(negedge clk);
      drive(2'b01, 1'b0, 32'd11, 32'd13, 32'd2, 4'b0010);
      e.r = m_res(2'b01, 32'd11, 32'd13, 32'd2);
      e.f = 4'b0010;
      e.cyc = cyc + 1 + LAT;
      e.tag = "R10 running op untouched";
      sb.push_back(e);
      prev = n_done;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      drive(2'b00, 1'b1, 32'd0, 32'd0, 32'd0, 4'b1111);
      @(negedge clk);
      start = 1'b0;
      while (n_done == prev) @(negedge clk);
      repeat (LAT + 4) @(negedge clk);
      check(n_done == prev + 1 && sb.size() == 0, "R10 single done", 64'(n_done - prev), 64'd1);
    end

    for (int i = 0; i < 40; i++) begin
      logic [1:0] op;
      string tg;
      op = 2'($urandom_range(0, 3));
      case (op)
        2'b01:   tg = "R2 random";
        2'b10:   tg = "R3 random";
        2'b11:   tg = "R4 random";
        default: tg = "R1 random";
      endcase
      run(op, 1'($urandom_range(0, 1)), $urandom, $urandom, $urandom, 4'($urandom_range(0, 15)), tg);
    end

    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R9 all results seen", 64'(sb.size()), 64'd0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule